// File: doc/BRIEF.md
# Floating-Point Operand Unpacker and Classifier

This block sits in front of a floating-point datapath and turns a packed IEEE-754 word into the form that arithmetic stages work on. A 64-bit double-precision word, or a 32-bit single-precision word when the mode input asks for it, is split into sign, exponent and fraction. The block then produces four things: the sign, an unbiased two's-complement exponent, a widened mantissa with three guard bits below the fraction, and a two-bit class tag.

Finite nonzero inputs always leave with their leading one at one fixed bit position. That position is bit 55 for double precision and bit 26 for single precision. Subnormal inputs are brought there by a leading-zero count and a left shift, and their exponent is lowered by the same amount, so the represented value does not change. A downstream stage therefore never has to handle subnormals as a separate case.

The output bundle is registered. It loads only when the input valid is high, and the output valid follows the input valid by one clock.

Top module: `fp_operand_unpack`

## Requirements
- R1: `out_valid` equals `in_valid` from the previous clock edge; while `rst_n` is low, `out_valid`, `out_sign`, `out_exp`, `out_mant` and `out_class` are all zero.
- R2: In double mode the sign is bit 63, the exponent field is bits 62:52 and the fraction is bits 51:0; `out_sign` copies the sign bit for every class.
- R3: The class codes are 0 normal, 1 zero, 2 infinity and 3 NaN. An all-ones exponent field gives infinity when the fraction is zero and NaN otherwise.
- R4: A zero exponent field with a zero fraction gives class zero, with `out_exp` = 0 and `out_mant` = 0, whatever the sign.
- R5: For a double normal input, `out_exp` = field − 1023 and `out_mant` = (2^52 + fraction) · 8, so bit 55 is the leading one.
- R6: For a double subnormal input, take lz as the leading-zero count of the fraction zero-extended to 64 bits. Then `out_mant` = fraction · 2^(lz−8), which puts the leading one at bit 55, and `out_exp` = −1011 − lz. A fraction of 1 gives −1074.
- R7: When `in_single` is 1, only bits 31:0 are used: sign at bit 31, exponent at 30:23, fraction at 22:0, bias 127. A normal input gives `out_mant` = (2^23 + fraction) · 8, with the leading one at bit 26, and bits 63:32 have no effect.
- R8: For a single subnormal input, `out_mant` = fraction · 2^(lz−37), with the leading one at bit 26, and `out_exp` = −86 − lz. A fraction of 1 gives −149.
- R9: For infinity and NaN in either mode, `out_exp` = 0 and `out_mant` = fraction · 8, so the NaN payload is kept.
- R10: While `in_valid` is low, the bundle (`out_sign`, `out_exp`, `out_mant`, `out_class`) keeps its last loaded value.
- R11: `out_exp` is a 13-bit two's-complement value, and for normal-class results it lies in −1074 … 1023.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word is valid; loads the bundle |
| in_word | input | 64 | Packed operand (single precision uses bits 31:0) |
| in_single | input | 1 | 1 selects single-precision decoding |
| out_valid | output | 1 | Bundle was loaded at the last edge |
| out_sign | output | 1 | Operand sign |
| out_exp | output | 13 | Unbiased exponent, two's complement |
| out_mant | output | 56 | Mantissa with implied one and three guard bits |
| out_class | output | 2 | 0 normal, 1 zero, 2 infinity, 3 NaN |

## Verification
The bench uses directed words at the class boundaries in both precisions: ±1.0, the largest and smallest normals, signed zeros, infinities, quiet and signalling NaNs, and subnormals from a fraction of 1 up to an all-ones fraction. Together these separate the four classes and show whether the subnormal shift and exponent are off by one. Single-mode words carry random junk in bits 63:32, which exposes any leak from the upper half. Random words with the exponent field forced to zero or all ones, or with the fraction shortened, spread the leading-zero count over its whole range. Idle cycles with a changing input word show whether the bundle really holds when it should not load.

// File: rtl/fpu_unpack_pkg.sv
package fpu_unpack_pkg;

  localparam int DP_W      = 64;
  localparam int DP_EXP_W  = 11;
  localparam int DP_FRAC_W = 52;
  localparam int SP_W      = 32;
  localparam int SP_EXP_W  = 8;
  localparam int SP_FRAC_W = 23;
  localparam int GUARD_W   = 3;
  localparam int MANT_W    = DP_FRAC_W + 1 + GUARD_W;
  localparam int EXP_OUT_W = 13;
  localparam int LZ_W      = $clog2(DP_W);

  typedef enum logic [1:0] {
    CLS_NORM = 2'd0,
    CLS_ZERO = 2'd1,
    CLS_INF  = 2'd2,
    CLS_NAN  = 2'd3
  } fp_class_e;

  typedef struct packed {
    logic                        sign;
    logic signed [EXP_OUT_W-1:0] exp;
    logic [MANT_W-1:0]           mant;
    fp_class_e                   cls;
  } unpacked_t;

endpackage

// File: rtl/fp_field_split.sv
module fp_field_split
  import fpu_unpack_pkg::*;
#(
  parameter bit SP_EN = 1'b1
) (
  input  logic [DP_W-1:0]     word_i,
  input  logic                sp_req_i,
  output logic                sign_o,
  output logic [DP_EXP_W-1:0] efld_o,
  output logic [DP_W-1:0]     frac_o,
  output logic                sp_o
);

  localparam int SP_EPAD = DP_EXP_W - SP_EXP_W;
  localparam int SP_FPAD = DP_W - SP_FRAC_W;
  localparam int DP_FPAD = DP_W - DP_FRAC_W;

  logic                dp_sign, sp_sign;
  logic [DP_EXP_W-1:0] dp_efld, sp_efld;
  logic [DP_W-1:0]     dp_frac, sp_frac;

  assign dp_sign = word_i[DP_W-1];
  assign dp_efld = word_i[DP_W-2 -: DP_EXP_W];
  assign dp_frac = {{DP_FPAD{1'b0}}, word_i[DP_FRAC_W-1:0]};

  assign sp_sign = word_i[SP_W-1];
  assign sp_efld = {{SP_EPAD{1'b0}}, word_i[SP_W-2 -: SP_EXP_W]};
  assign sp_frac = {{SP_FPAD{1'b0}}, word_i[SP_FRAC_W-1:0]};

  generate
    if (SP_EN) begin : g_dual
      assign sp_o = sp_req_i;
      always_comb begin
        if (sp_req_i) begin
          sign_o = sp_sign;
          efld_o = sp_efld;
          frac_o = sp_frac;
        end else begin
          sign_o = dp_sign;
          efld_o = dp_efld;
          frac_o = dp_frac;
        end
      end
    end else begin : g_dp_only
      logic unused_sp;
      assign unused_sp = sp_req_i ^ sp_sign ^ (|sp_efld) ^ (|sp_frac);
      assign sp_o   = 1'b0;
      assign sign_o = dp_sign;
      assign efld_o = dp_efld;
      assign frac_o = dp_frac;
    end
  endgenerate

endmodule

// File: rtl/fp_lzc.sv
module fp_lzc #(
  parameter int W = 64,
  localparam int LG = $clog2(W)
) (
  input  logic [W-1:0]  vec_i,
  output logic [LG-1:0] cnt_o
);

  logic [LG:0][W-1:0] win;

  assign win[0] = vec_i;

  generate
    for (genvar g = 0; g < LG; g++) begin : g_step
      localparam int SPAN = 1 << (LG - 1 - g);
      logic empty;
      assign empty      = ~|win[g][W-1 -: SPAN];
      assign win[g+1]   = empty ? (win[g] << SPAN) : win[g];
      assign cnt_o[LG-1-g] = empty;
    end
  endgenerate

endmodule

// File: rtl/fp_class_norm.sv
module fp_class_norm
  import fpu_unpack_pkg::*;
(
  input  logic                sign_i,
  input  logic [DP_EXP_W-1:0] efld_i,
  input  logic [DP_W-1:0]     frac_i,
  input  logic                sp_i,
  input  logic [LZ_W-1:0]     lz_i,
  output unpacked_t           res_o
);

  localparam int SHW     = LZ_W + 1;
  localparam int DP_BIAS = (1 << (DP_EXP_W - 1)) - 1;
  localparam int SP_BIAS = (1 << (SP_EXP_W - 1)) - 1;
  localparam int DP_LEAD = DP_FRAC_W + GUARD_W;
  localparam int SP_LEAD = SP_FRAC_W + GUARD_W;
  localparam logic [DP_EXP_W-1:0] DP_EMAX = {DP_EXP_W{1'b1}};
  localparam logic [DP_EXP_W-1:0] SP_EMAX =
    {{(DP_EXP_W - SP_EXP_W){1'b0}}, {SP_EXP_W{1'b1}}};
  localparam logic [SHW-1:0] DP_SUB_OFF = SHW'(DP_W - 1 - DP_LEAD);
  localparam logic [SHW-1:0] SP_SUB_OFF = SHW'(DP_W - 1 - SP_LEAD);

  logic [DP_EXP_W-1:0]         emax;
  logic signed [EXP_OUT_W-1:0] bias;
  logic [DP_W-1:0]             implied;
  logic [SHW-1:0]              sub_sh;
  logic [DP_W-1:0]             norm_m, sub_m, spec_m;
  logic signed [EXP_OUT_W-1:0] norm_e, sub_e;
  logic                        frac_zero;

  always_comb begin
    emax      = sp_i ? SP_EMAX : DP_EMAX;
    bias      = sp_i ? EXP_OUT_W'(SP_BIAS) : EXP_OUT_W'(DP_BIAS);
    implied   = sp_i ? (DP_W'(1) << SP_FRAC_W) : (DP_W'(1) << DP_FRAC_W);
    frac_zero = (frac_i == '0);
    sub_sh    = {1'b0, lz_i} - (sp_i ? SP_SUB_OFF : DP_SUB_OFF);
    norm_m    = (frac_i | implied) << GUARD_W;
    sub_m     = frac_i << sub_sh;
    spec_m    = frac_i << GUARD_W;
    norm_e    = $signed({{(EXP_OUT_W - DP_EXP_W){1'b0}}, efld_i}) - bias;
    sub_e     = EXP_OUT_W'(1 + GUARD_W) - bias
              - $signed({{(EXP_OUT_W - SHW){1'b0}}, sub_sh});
  end

  always_comb begin
    res_o.sign = sign_i;
    if (efld_i == emax) begin
      res_o.cls  = frac_zero ? CLS_INF : CLS_NAN;
      res_o.exp  = '0;
      res_o.mant = spec_m[MANT_W-1:0];
    end else if (efld_i == '0) begin
      if (frac_zero) begin
        res_o.cls  = CLS_ZERO;
        res_o.exp  = '0;
        res_o.mant = '0;
      end else begin
        res_o.cls  = CLS_NORM;
        res_o.exp  = sub_e;
        res_o.mant = sub_m[MANT_W-1:0];
      end
    end else begin
      res_o.cls  = CLS_NORM;
      res_o.exp  = norm_e;
      res_o.mant = norm_m[MANT_W-1:0];
    end
  end

endmodule

// File: rtl/fp_operand_unpack.sv
module fp_operand_unpack
  import fpu_unpack_pkg::*;
#(
  parameter bit SP_EN = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [DP_W-1:0]      in_word,
  input  logic                 in_single,
  output logic                 out_valid,
  output logic                 out_sign,
  output logic [EXP_OUT_W-1:0] out_exp,
  output logic [MANT_W-1:0]    out_mant,
  output logic [1:0]           out_class
);

  logic                sp_sign;
  logic [DP_EXP_W-1:0] sp_efld;
  logic [DP_W-1:0]     sp_frac;
  logic                sp_mode;
  logic [LZ_W-1:0]     lz_cnt;
  unpacked_t           res_c;
  unpacked_t           bund_d, bund_q;
  logic                vld_d, vld_q;

  fp_field_split #(.SP_EN(SP_EN)) u_split (
    .word_i   (in_word),
    .sp_req_i (in_single),
    .sign_o   (sp_sign),
    .efld_o   (sp_efld),
    .frac_o   (sp_frac),
    .sp_o     (sp_mode)
  );

  fp_lzc #(.W(DP_W)) u_lzc (
    .vec_i (sp_frac),
    .cnt_o (lz_cnt)
  );

  fp_class_norm u_norm (
    .sign_i (sp_sign),
    .efld_i (sp_efld),
    .frac_i (sp_frac),
    .sp_i   (sp_mode),
    .lz_i   (lz_cnt),
    .res_o  (res_c)
  );

  always_comb begin
    vld_d  = in_valid;
    bund_d = bund_q;
    if (in_valid) begin
      bund_d = res_c;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      bund_q <= '0;
    end else begin
      vld_q  <= vld_d;
      bund_q <= bund_d;
    end
  end

  assign out_valid = vld_q;
  assign out_sign  = bund_q.sign;
  assign out_exp   = bund_q.exp;
  assign out_mant  = bund_q.mant;
  assign out_class = bund_q.cls;

endmodule

// File: rtl/fp_unpack_chk.sv
module fp_unpack_chk
  import fpu_unpack_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 out_valid,
  input logic                 out_sign,
  input logic [EXP_OUT_W-1:0] out_exp,
  input logic [MANT_W-1:0]    out_mant,
  input logic [1:0]           out_class
);

  localparam int DP_LEAD = DP_FRAC_W + GUARD_W;
  localparam int SP_LEAD = SP_FRAC_W + GUARD_W;

  logic armed;
  logic loaded;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed  <= 1'b0;
      loaded <= 1'b0;
    end else begin
      armed  <= 1'b1;
      loaded <= loaded | out_valid;
    end
  end

  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> out_valid == $past(in_valid));

  // R10
  bundle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !$past(in_valid)) |->
      ($stable(out_mant) && $stable(out_exp) && $stable(out_class) && $stable(out_sign)));

  // R4
  zero_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (loaded && out_class == CLS_ZERO) |-> (out_mant == '0 && out_exp == '0));

  // R3
  nan_payload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (loaded && out_class == CLS_NAN) |-> out_mant != '0);

  // R9
  inf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (loaded && out_class == CLS_INF) |-> (out_mant == '0 && out_exp == '0));

  // R5
  lead_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (loaded && out_class == CLS_NORM) |->
      (out_mant[DP_LEAD] ||
       (out_mant[MANT_W-1:SP_LEAD+1] == '0 && out_mant[SP_LEAD])));

  // R11
  exp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (loaded && out_class == CLS_NORM) |->
      ($signed(out_exp) >= -13'sd1074 && $signed(out_exp) <= 13'sd1023));

endmodule

bind fp_operand_unpack fp_unpack_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .out_sign  (out_sign),
  .out_exp   (out_exp),
  .out_mant  (out_mant),
  .out_class (out_class)
);

// File: tb/tb_fp_operand_unpack.sv
module tb_fp_operand_unpack;
  import fpu_unpack_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [63:0] in_word;
  logic        in_single;
  logic        out_valid;
  logic        out_sign;
  logic [12:0] out_exp;
  logic [55:0] out_mant;
  logic [1:0]  out_class;

  always #10 clk = ~clk;

  fp_operand_unpack dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
    .in_single(in_single), .out_valid(out_valid), .out_sign(out_sign),
    .out_exp(out_exp), .out_mant(out_mant), .out_class(out_class)
  );

  int n_chk = 0;
  int n_bad = 0;

  // reference state: what the bundle should hold after the last edge
  logic        m_valid;
  logic        m_sign;
  int          m_exp;
  logic [63:0] m_mant;
  logic [1:0]  m_cls;
  string       m_tag;
  logic        m_idle;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chk_int(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic void ref_unpack(input logic [63:0] w, input logic sp,
                                     output logic s, output int e,
                                     output logic [63:0] m, output logic [1:0] c,
                                     output string tag);
    int ef, emax, bias, fw, p;
    logic [63:0] f;
    if (sp) begin
      s = w[31]; ef = int'(w[30:23]); f = {41'd0, w[22:0]};
      emax = 255; bias = 127; fw = 23;
    end else begin
      s = w[63]; ef = int'(w[62:52]); f = {12'd0, w[51:0]};
      emax = 2047; bias = 1023; fw = 52;
    end
    if (ef == emax) begin
      c = (f == 0) ? 2'd2 : 2'd3;
      e = 0; m = f << 3;
      tag = sp ? "R9 single special" : "R3 R9 double special";
    end else if (ef == 0) begin
      if (f == 0) begin
        c = 2'd1; e = 0; m = 0;
        tag = "R4 zero";
      end else begin
        p = 0;
        for (int i = 0; i < 64; i++) if (f[i]) p = i;
        c = 2'd0;
        m = f << (fw + 3 - p);
        e = p - fw - (bias - 1);
        tag = sp ? "R8 single subnormal" : "R6 double subnormal";
      end
    end else begin
      c = 2'd0;
      e = ef - bias;
      m = (f | (64'd1 << fw)) << 3;
      tag = sp ? "R7 single normal" : "R5 double normal";
    end
  endfunction

  task automatic compare();
    string t;
    chk("R1 valid", {63'd0, out_valid}, {63'd0, m_valid});
    t = m_idle ? {"R10 hold ", m_tag} : m_tag;
    chk({"R2 sign ", t}, {63'd0, out_sign}, {63'd0, m_sign});
    chk_int({t, " R11 exp"}, int'($signed(out_exp)), m_exp);
    chk({t, " mant"}, {8'd0, out_mant}, m_mant);
    chk({t, " R3 class"}, {62'd0, out_class}, {62'd0, m_cls});
  endtask

  task automatic step(input logic v, input logic [63:0] w, input logic sp);
    logic s; int e; logic [63:0] m; logic [1:0] c; string tg;
    @(negedge clk);
    compare();
    in_valid = v; in_word = w; in_single = sp;
    m_valid = v;
    if (v) begin
      ref_unpack(w, sp, s, e, m, c, tg);
      m_sign = s; m_exp = e; m_mant = m; m_cls = c; m_tag = tg; m_idle = 1'b0;
    end else begin
      m_idle = 1'b1;
    end
  endtask

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL R1 watchdog expired act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [63:0] w;
    logic sp;
    rst_n = 1'b0; in_valid = 1'b0; in_word = 64'h7FF8_0000_0000_0001; in_single = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state: all outputs zero while reset is low
    chk("R1 reset valid", {63'd0, out_valid}, 64'd0);
    chk("R1 reset bundle", {5'd0, out_sign, out_exp, out_mant[43:0]}, 64'd0);
    chk("R1 reset mant/class", {6'd0, out_mant, out_class}, 64'd0);
    rst_n = 1'b1;
    in_word = 64'd0;
    m_valid = 1'b0; m_sign = 1'b0; m_exp = 0; m_mant = 64'd0; m_cls = 2'd0;
    m_tag = "R1 post-reset"; m_idle = 1'b1;

    // double directed
    step(1, 64'h3FF0_0000_0000_0000, 0);
    step(1, 64'hC004_0000_0000_0000, 0);
    step(1, 64'h7FEF_FFFF_FFFF_FFFF, 0);
    step(1, 64'h0010_0000_0000_0000, 0);
    step(1, 64'h0000_0000_0000_0000, 0);
    step(1, 64'h8000_0000_0000_0000, 0);
    step(1, 64'h7FF0_0000_0000_0000, 0);
    step(1, 64'hFFF0_0000_0000_0000, 0);
    step(1, 64'h7FF8_0000_0000_0000, 0);
    step(1, 64'h7FF0_0000_0000_0001, 0);
    step(1, 64'h0000_0000_0000_0001, 0);
    step(1, 64'h800F_FFFF_FFFF_FFFF, 0);
    step(1, 64'h0008_0000_0000_0000, 0);
    step(1, 64'h0000_0000_0008_0000, 0);
    // idle cycles with a changing word: bundle must hold (R10)
    step(0, 64'h3FF0_0000_0000_0000, 0);
    step(0, 64'hFFFF_FFFF_FFFF_FFFF, 1);
    step(0, 64'h0000_0000_0000_0000, 0);
    // single directed, junk in upper half (R7)
    step(1, 64'hDEAD_BEEF_3F80_0000, 1);
    step(1, 64'hFFFF_FFFF_0000_0001, 1);
    step(1, 64'h1234_5678_807F_FFFF, 1);
    step(1, 64'hA5A5_A5A5_7F80_0000, 1);
    step(1, 64'h0000_0000_FFC0_0001, 1);
    step(1, 64'h7FF0_0000_7F7F_FFFF, 1);
    step(1, 64'h0000_0000_0080_0000, 1);
    step(1, 64'hFFFF_FFFF_8000_0000, 1);
    step(1, 64'h0000_0000_0000_4000, 1);
    step(0, 64'h0000_0000_3F80_0000, 1);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      w  = {$urandom(), $urandom()};
      sp = ($urandom() % 3) == 0;
      case ($urandom() % 6)
        0: if (sp) w[30:23] = 8'd0;  else w[62:52] = 11'd0;
        1: if (sp) w[30:23] = 8'hFF; else w[62:52] = 11'h7FF;
        2: begin
          if (sp) begin w[30:23] = 8'd0;  w[22:0]  = w[22:0]  >> ($urandom() % 23); end
          else    begin w[62:52] = 11'd0; w[51:0]  = w[51:0]  >> ($urandom() % 52); end
        end
        3: if (sp) w[22:0] = 23'd0; else w[51:0] = 52'd0;
        default: ;
      endcase
      step(($urandom() % 5) != 0, w, sp);
    end
    step(0, 64'd0, 0);
    step(0, 64'd0, 0);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule